// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

The unit watches 28 general-purpose input pins and raises interrupt requests when a pin shows an edge of a kind that software has enabled. Every pin has a rising-edge enable bit and a falling-edge enable bit. With both set, either edge is caught; with both clear, the pin is masked. A detected edge sets a sticky bit in the edge status register, and that bit holds until software writes a one to it.

Pins 0 to 10 each drive their own interrupt line. The status bits of pins 11 to 27 are OR-ed onto one shared line, and software works out which pin fired by reading the status register. A separate wake mask picks the pins whose pending edges assert a wake output. Pin inputs first pass through a two-flop synchronizer. Edges are found by comparing the synchronized level with the level seen one cycle earlier.

Software reaches the four registers over a simple 32-bit bus with valid, write and address signals. Read data is registered and appears on the cycle after the request.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset the rising enables, falling enables, status and wake mask all read as zero, and irq_direct_o, irq_shared_o and wake_o are low.
- R2: When rising enable bit i is set, a 0-to-1 change on pins_i[i] sets status bit i.
- R3: When only falling enable bit i is set, a 1-to-0 change on pins_i[i] sets status bit i, and a 0-to-1 change does not.
- R4: With both enables set for a pin, either edge sets its status bit. With neither set, no change on that pin sets its status bit.
- R5: A status bit stays set until a write clears it, even after the pin returns to its earlier level.
- R6: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged, so writing back a value just read clears all pending bits.
- R7: If a new enabled edge and a write-one-to-clear of the same status bit take effect on the same clock edge, the bit stays set.
- R8: irq_direct_o[i] equals status bit i for i from 0 to 10.
- R9: irq_shared_o is high exactly when any of status bits 11 to 27 is set.
- R10: wake_o is high exactly when some status bit is set whose wake mask bit is also set.
- R11: bus_addr_i[3:2] selects the register: 0 rising enables, 1 falling enables, 2 status, 3 wake mask (byte offsets 0x0, 0x4, 0x8, 0xC). Bit i of each register belongs to pin i. Bits 31:28 read as zero and ignore writes. A read updates bus_rdata_o on the clock edge that accepts it, and bus_rdata_o holds its value otherwise.
- R12: A pin change applied between clock edges shows in the status register, and therefore on the interrupt outputs, after the third rising clock edge that follows it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | 28 | Asynchronous pin levels |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 for a write, 0 for a read |
| bus_addr_i | input | 4 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_direct_o | output | 11 | Dedicated interrupts for pins 0 to 10 |
| irq_shared_o | output | 1 | Combined interrupt for pins 11 to 27 |
| wake_o | output | 1 | Wake request from masked pending edges |

## Verification
The bench makes an edge land on the same clock edge as a clear of the same bit. A design that lets the clear win would lose that interrupt, and the status read would come back zero. It drives pins whose enables are off or point at the other polarity, where a design that ignores the enables would set bits that should stay clear. It writes zeros to the status register and then writes back a value read from it, which catches a design that stores the written value or clears the whole register. It also counts the clocks between a pin change and its interrupt, so a missing or extra synchronizer stage moves the interrupt by a cycle and is caught.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  typedef enum logic [1:0] {
    SEL_RISE = 2'd0,
    SEL_FALL = 2'd1,
    SEL_STAT = 2'd2,
    SEL_WAKE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int unsigned WIDTH = 28
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] rise_en_i,
  input  logic [WIDTH-1:0] fall_en_i,
  output logic [WIDTH-1:0] hit_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  assign hit_o = (sync_i & ~prev_q & rise_en_i) | (~sync_i & prev_q & fall_en_i);

  // R4: a pin with both enables clear never reports
  a_r4_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o & ~(rise_en_i | fall_en_i)) == '0);
  // R2: a hit at high level needs the rising enable
  a_r2_rise_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o & sync_i & ~rise_en_i) == '0);
  // R3: a hit at low level needs the falling enable
  a_r3_fall_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o & ~sync_i & ~fall_en_i) == '0);
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS = 28,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_valid_i,
  input  logic                bus_write_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [DATA_W-1:0]   bus_wdata_i,
  output logic [DATA_W-1:0]   bus_rdata_o,
  input  logic [NUM_PINS-1:0] hit_i,
  output logic [NUM_PINS-1:0] rise_en_o,
  output logic [NUM_PINS-1:0] fall_en_o,
  output logic [NUM_PINS-1:0] wake_en_o,
  output logic [NUM_PINS-1:0] status_o
);
  logic [NUM_PINS-1:0] rise_q, fall_q, wake_q, stat_q;
  logic [DATA_W-1:0]   rdata_q, rdata_d;
  logic [NUM_PINS-1:0] wval, clr_mask;
  reg_sel_e            sel;
  logic                wr_en, rd_en;

  assign sel   = reg_sel_e'(bus_addr_i[3:2]);
  assign wr_en = bus_valid_i & bus_write_i;
  assign rd_en = bus_valid_i & ~bus_write_i;
  assign wval  = bus_wdata_i[NUM_PINS-1:0];
  assign clr_mask = (wr_en && sel == SEL_STAT) ? wval : '0;

  generate
    if (NUM_PINS < DATA_W) begin : g_unused_hi
      logic unused_hi;
      assign unused_hi = ^bus_wdata_i[DATA_W-1:NUM_PINS];
    end
    if (ADDR_W > 4) begin : g_unused_addr_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^bus_addr_i[ADDR_W-1:4];
    end
  endgenerate
  logic unused_addr_lo;
  assign unused_addr_lo = ^bus_addr_i[1:0];

  always_comb begin
    unique case (sel)
      SEL_RISE: rdata_d = DATA_W'(rise_q);
      SEL_FALL: rdata_d = DATA_W'(fall_q);
      SEL_STAT: rdata_d = DATA_W'(stat_q);
      default:  rdata_d = DATA_W'(wake_q);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q  <= '0;
      fall_q  <= '0;
      wake_q  <= '0;
      stat_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en && sel == SEL_RISE) rise_q <= wval;
      if (wr_en && sel == SEL_FALL) fall_q <= wval;
      if (wr_en && sel == SEL_WAKE) wake_q <= wval;
      // new edge beats a same-cycle clear
      stat_q <= (stat_q & ~clr_mask) | hit_i;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign rise_en_o   = rise_q;
  assign fall_en_o   = fall_q;
  assign wake_en_o   = wake_q;
  assign status_o    = stat_q;
  assign bus_rdata_o = rdata_q;

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_mask == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  a_r7_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i != '0) |=> ((stat_q & $past(hit_i)) == $past(hit_i)));
  a_r6_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_mask != '0) |=> ((stat_q & $past(clr_mask & ~hit_i)) == '0));
  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> $stable(bus_rdata_o));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int unsigned NUM_PINS   = 28,
  parameter int unsigned NUM_DIRECT = 11,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   pins_i,
  input  logic                  bus_valid_i,
  input  logic                  bus_write_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  output logic [NUM_DIRECT-1:0] irq_direct_o,
  output logic                  irq_shared_o,
  output logic                  wake_o
);
  localparam int unsigned NUM_SHARED = NUM_PINS - NUM_DIRECT;

  logic [NUM_PINS-1:0] sync, hit, rise_en, fall_en, wake_en, status;

  gpio_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i, .rst_ni, .async_i(pins_i), .sync_o(sync)
  );

  gpio_edge_det #(.WIDTH(NUM_PINS)) u_det (
    .clk_i, .rst_ni, .sync_i(sync), .rise_en_i(rise_en),
    .fall_en_i(fall_en), .hit_o(hit)
  );

  gpio_edge_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .bus_valid_i, .bus_write_i, .bus_addr_i, .bus_wdata_i,
    .bus_rdata_o, .hit_i(hit), .rise_en_o(rise_en), .fall_en_o(fall_en),
    .wake_en_o(wake_en), .status_o(status)
  );

  assign irq_direct_o = status[NUM_DIRECT-1:0];
  assign irq_shared_o = |status[NUM_PINS-1 -: NUM_SHARED];
  assign wake_o       = |(status & wake_en);
endmodule

// File: tb/sim_gpio_edge_irq.sv
`timescale 1ns/1ps
module sim_gpio_edge_irq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [27:0] pins_i = '0;
  logic        bus_valid_i = 1'b0, bus_write_i = 1'b0;
  logic [3:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [10:0] irq_direct_o;
  logic        irq_shared_o, wake_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  gpio_edge_irq u0 (.*);

  // behavioural reference
  logic [27:0] hist[$];
  logic [27:0] m_rise, m_fall, m_wake, m_stat;
  logic [31:0] m_rdata;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = '{28'h0, 28'h0, 28'h0};
      m_rise = '0; m_fall = '0; m_wake = '0; m_stat = '0; m_rdata = '0;
    end else begin
      logic [27:0] now_l, old_l, ev, clr;
      now_l = hist[1];
      old_l = hist[2];
      ev  = (now_l & ~old_l & m_rise) | (~now_l & old_l & m_fall);
      clr = '0;
      if (bus_valid_i && !bus_write_i) begin
        case (bus_addr_i[3:2])
          2'd0: m_rdata = {4'h0, m_rise};
          2'd1: m_rdata = {4'h0, m_fall};
          2'd2: m_rdata = {4'h0, m_stat};
          default: m_rdata = {4'h0, m_wake};
        endcase
      end
      if (bus_valid_i && bus_write_i) begin
        case (bus_addr_i[3:2])
          2'd0: m_rise = bus_wdata_i[27:0];
          2'd1: m_fall = bus_wdata_i[27:0];
          2'd2: clr = bus_wdata_i[27:0];
          default: m_wake = bus_wdata_i[27:0];
        endcase
      end
      m_stat = (m_stat & ~clr) | ev;
      hist.push_front(pins_i);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R11 rdata vs model", bus_rdata_o, m_rdata);
      chk("R8 irq_direct vs model", {21'h0, irq_direct_o}, {21'h0, m_stat[10:0]});
      chk("R9 irq_shared vs model", {31'h0, irq_shared_o}, {31'h0, |m_stat[27:11]});
      chk("R10 wake vs model", {31'h0, wake_o}, {31'h0, |(m_stat & m_wake)});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    bus_valid_i = 1; bus_write_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_valid_i = 0; bus_write_i = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_valid_i = 1; bus_write_i = 0; bus_addr_i = a;
    @(negedge clk_i);
    bus_valid_i = 0;
    d = bus_rdata_o;
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk_i);
    pins_i[i] = v;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    settle(3);
    rst_ni = 1;
    settle(2);
    // R1 reset state
    for (int a = 0; a < 16; a += 4) begin
      rd(4'(a), v);
      chk("R1 reset reg", v, 32'h0);
    end
    chk("R1 irq_direct", {21'h0, irq_direct_o}, 32'h0);
    chk("R1 shared/wake", {30'h0, irq_shared_o, wake_o}, 32'h0);

    // R2 rising detection, R8/R9 fan-out
    wr(4'h0, 32'h0000_8001);
    set_pin(0, 1); set_pin(15, 1); settle(4);
    rd(4'h8, v); chk("R2 rise sets status", v, 32'h0000_8001);
    chk("R8 direct line 0", {21'h0, irq_direct_o}, 32'h1);
    chk("R9 shared from pin 15", {31'h0, irq_shared_o}, 32'h1);

    // R6 write-one-to-clear
    wr(4'h8, 32'h0);
    rd(4'h8, v); chk("R6 zero write no effect", v, 32'h0000_8001);
    wr(4'h8, 32'h1);
    rd(4'h8, v); chk("R6 one clears only bit0", v, 32'h0000_8000);
    chk("R8 direct line cleared", {21'h0, irq_direct_o}, 32'h0);

    // R5 sticky
    set_pin(0, 0); set_pin(15, 0); settle(4);
    rd(4'h8, v); chk("R5 sticky after level return", v, 32'h0000_8000);
    wr(4'h8, 32'h0000_8000);
    chk("R9 shared drops on clear", {31'h0, irq_shared_o}, 32'h0);

    // R12 latency
    wr(4'h0, 32'h0000_8005);
    set_pin(2, 1);
    @(negedge clk_i); chk("R12 after edge 1", {31'h0, irq_direct_o[2]}, 32'h0);
    @(negedge clk_i); chk("R12 after edge 2", {31'h0, irq_direct_o[2]}, 32'h0);
    @(negedge clk_i); chk("R12 after edge 3", {31'h0, irq_direct_o[2]}, 32'h1);

    // R3 falling only
    wr(4'h4, 32'h0010_0000);
    set_pin(20, 1); settle(4);
    rd(4'h8, v); chk("R3 rise ignored", v, 32'h0000_0004);
    set_pin(20, 0); settle(4);
    rd(4'h8, v); chk("R3 fall sets status", v, 32'h0010_0004);

    // R10 wake
    chk("R10 wake off without mask", {31'h0, wake_o}, 32'h0);
    wr(4'hC, 32'h0010_0000);
    chk("R10 wake on", {31'h0, wake_o}, 32'h1);
    wr(4'hC, 32'h0000_0020);
    chk("R10 wake off for idle pin", {31'h0, wake_o}, 32'h0);

    // R4 both edges and no enable
    wr(4'h0, 32'h0000_8025);
    wr(4'h4, 32'h0010_0020);
    set_pin(5, 1); settle(4);
    rd(4'h8, v); chk("R4 both: rise", v, 32'h0010_0024);
    chk("R10 wake for pin 5", {31'h0, wake_o}, 32'h1);
    wr(4'h8, 32'h20);
    set_pin(5, 0); settle(4);
    rd(4'h8, v); chk("R4 both: fall", v, 32'h0010_0024);
    set_pin(6, 1); settle(4); set_pin(6, 0); settle(4);
    rd(4'h8, v); chk("R4 no enable ignored", v, 32'h0010_0024);

    // R6 write back read value
    rd(4'h8, v);
    wr(4'h8, v);
    rd(4'h8, v); chk("R6 write-back clears all", v, 32'h0);
    chk("R6 outputs idle", {20'h0, irq_direct_o, irq_shared_o}, 32'h0);

    // R7 edge vs clear collision
    wr(4'h0, 32'h0000_802D);
    set_pin(3, 1); settle(4);
    rd(4'h8, v); chk("R2 pin3 set", v, 32'h8);
    set_pin(3, 0); settle(4);
    set_pin(3, 1);
    @(negedge clk_i);
    wr(4'h8, 32'h8);
    rd(4'h8, v); chk("R7 edge wins over clear", v, 32'h8);

    // R11 map and unused bits
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); chk("R11 high bits zero", v, 32'h0FFF_FFFF);
    rd(4'h4, v); chk("R11 falling reg", v, 32'h0010_0020);
    rd(4'hC, v); chk("R11 wake reg", v, 32'h0000_0020);
    settle(2);
    finish_run();
  end
endmodule